// File: doc/BRIEF.md
# Multi-Level Branch Target Predictor

This block looks past the branch that is executing now and forecasts where control will go several dynamic branches later. An instruction prefetcher can then request that line early enough to hide the second-level cache latency. Each time a branch executes, the block is told its PC, its resolved direction and its resolved target. One cycle later it gives a prediction flag and a predicted prefetch address.

The block has a direct-mapped table and a short history of recent branch PCs. Each table entry holds 2^LOOK candidate targets, and each candidate has a 2-bit saturating confidence counter. A lookup uses the PC of the current branch. Training uses a different PC: the target of a taken branch is recorded in the entry of the branch LOOK positions earlier. The table therefore learns what follows that older branch LOOK branches later. With LOOK set to 0 the structure reduces to an ordinary branch target buffer.

Top module: `lookahead_btb`

## Requirements
- R1: `pred_valid` and `pred_addr` are registered. They reflect the lookup made for a strobe (`br_valid` high) in the previous cycle. After any cycle without a strobe, and out of reset, `pred_valid` is 0.
- R2: A lookup uses entry `br_pc[IDX_W-1:0]` and compares the stored tag with `br_pc[PC_W-1:IDX_W]`. An invalid entry or a tag mismatch gives `pred_valid` 0.
- R3: On a tag hit, the reported address is the candidate with the highest counter. Ties go to the lowest candidate index. If that counter is 0, `pred_valid` is 0.
- R4: The history counts every strobed branch, taken or not. The table is not written until LOOK branches have been seen since reset.
- R5: A taken branch trains the entry that the PC of the branch LOOK strobes earlier selects. That PC is split into index and tag as in R2. A not-taken branch writes nothing to the table.
- R6: If the trained entry is invalid or has a different tag, it is allocated. All counters are cleared, the new target goes into candidate 0 with counter 1, and the tag is stored.
- R7: On a tag hit where a candidate with a nonzero counter already holds the target, that counter increments (saturating at 3). Every other counter in the entry decrements (saturating at 0).
- R8: On a tag hit where the target is absent, the candidate with the lowest counter is replaced (lowest index on ties), and its counter is set to 1. Every other counter decrements (saturating at 0).
- R9: With LOOK=0 the entry has one candidate, and a taken branch trains the entry of its own PC. The next lookup of that PC then predicts its target.
- R10: A lookup and an update in the same cycle see the table as it was before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch executes this cycle |
| br_pc | input | PC_W | PC of the executing branch |
| br_taken | input | 1 | Resolved direction, 1 = taken |
| br_target | input | PC_W | Resolved target address |
| pred_valid | output | 1 | Prediction available |
| pred_addr | output | PC_W | Predicted prefetch address |

## Verification
The assertions assume that `br_valid` and `br_taken` are never unknown once reset is released. They also assume that the PC and target are known whenever a strobe is high, so that table indexing and tag comparison act on defined values. The bench changes every input only on the falling clock edge and keeps every input at a defined value for the whole run. Strobe-free cycles are mixed in so that the idle properties on the table and the prediction flag are exercised. PCs are drawn from a few tags per index, which forces aliasing, reallocation and candidate replacement.

// File: rtl/lookahead_btb.sv
module lookahead_btb #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int LOOK  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_valid,
  input  logic [PC_W-1:0] br_pc,
  input  logic            br_taken,
  input  logic [PC_W-1:0] br_target,
  output logic            pred_valid,
  output logic [PC_W-1:0] pred_addr
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int NC    = 1 << LOOK;
  localparam int TAG_W = PC_W - IDX_W;
  localparam int CI_W  = (LOOK == 0) ? 1 : LOOK;
  localparam int HC_W  = $clog2(LOOK + 2);

  logic [TAG_W-1:0] tag_q  [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [PC_W-1:0]  addr_q [DEPTH][NC];
  logic [1:0]       cnt_q  [DEPTH][NC];

  logic [PC_W-1:0] src_pc;
  logic            hist_full;

  generate
    if (LOOK == 0) begin : g_nohist
      assign src_pc    = br_pc;
      assign hist_full = 1'b1;
    end else begin : g_hist
      logic [PC_W-1:0] hist_q [LOOK];
      logic [HC_W-1:0] hcnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          hcnt_q <= '0;
        end else if (br_valid) begin
          hist_q[LOOK-1] <= br_pc;
          for (int i = 0; i < LOOK - 1; i++) hist_q[i] <= hist_q[i+1];
          if (hcnt_q != HC_W'(LOOK)) hcnt_q <= hcnt_q + 1'b1;
        end
      end
      assign src_pc    = hist_q[0];
      assign hist_full = (hcnt_q == HC_W'(LOOK));
    end
  endgenerate

  wire [IDX_W-1:0] l_idx = br_pc[IDX_W-1:0];
  wire             l_hit = vld_q[l_idx] && (tag_q[l_idx] == br_pc[PC_W-1:IDX_W]);
  logic [CI_W-1:0] l_best;

  always_comb begin
    l_best = '0;
    for (int j = 1; j < NC; j++)
      if (cnt_q[l_idx][j] > cnt_q[l_idx][l_best]) l_best = CI_W'(j);
  end

  wire [IDX_W-1:0] u_idx  = src_pc[IDX_W-1:0];
  wire             u_hit  = vld_q[u_idx] && (tag_q[u_idx] == src_pc[PC_W-1:IDX_W]);
  wire             upd_en = br_valid && br_taken && hist_full;
  logic            m_found;
  logic [CI_W-1:0] m_sel, v_sel;

  always_comb begin
    m_found = 1'b0;
    m_sel   = '0;
    v_sel   = '0;
    for (int j = 0; j < NC; j++) begin
      if (!m_found && cnt_q[u_idx][j] != 2'd0 && addr_q[u_idx][j] == br_target) begin
        m_found = 1'b1;
        m_sel   = CI_W'(j);
      end
      if (cnt_q[u_idx][j] < cnt_q[u_idx][v_sel]) v_sel = CI_W'(j);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int e = 0; e < DEPTH; e++)
        for (int j = 0; j < NC; j++) cnt_q[e][j] <= 2'd0;
    end else if (upd_en) begin
      if (!u_hit) begin
        vld_q[u_idx] <= 1'b1;
        tag_q[u_idx] <= src_pc[PC_W-1:IDX_W];
        for (int j = 0; j < NC; j++) begin
          addr_q[u_idx][j] <= (j == 0) ? br_target : '0;
          cnt_q[u_idx][j]  <= (j == 0) ? 2'd1 : 2'd0;
        end
      end else begin
        for (int j = 0; j < NC; j++) begin
          if (m_found ? (CI_W'(j) == m_sel) : (CI_W'(j) == v_sel)) begin
            if (!m_found) addr_q[u_idx][j] <= br_target;
            cnt_q[u_idx][j] <= !m_found ? 2'd1 :
                               (cnt_q[u_idx][j] == 2'd3) ? 2'd3 : cnt_q[u_idx][j] + 2'd1;
          end else begin
            cnt_q[u_idx][j] <= (cnt_q[u_idx][j] == 2'd0) ? 2'd0 : cnt_q[u_idx][j] - 2'd1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_valid <= 1'b0;
      pred_addr  <= '0;
    end else begin
      pred_valid <= br_valid && l_hit && (cnt_q[l_idx][l_best] != 2'd0);
      pred_addr  <= addr_q[l_idx][l_best];
    end
  end

  AST_IDLE_NO_PRED: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> !pred_valid); // R1
  AST_PRED_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> $past(|vld_q)); // R2
  AST_HIST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !hist_full) |=> $stable(vld_q)); // R4
  AST_NOTTAKEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_taken) |=> $stable(vld_q)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> $stable(vld_q)); // R5
  AST_ALLOC_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !u_hit) |=> (cnt_q[$past(u_idx)][0] == 2'd1)); // R6
endmodule

// File: tb/sim_lookahead_btb.sv
module sim_lookahead_btb;
  localparam int CLK_NS = 10;
  localparam int KA = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic br_valid = 1'b0, br_taken = 1'b0;
  logic [31:0] br_pc = '0, br_target = '0;
  logic pv0, pv1;
  logic [31:0] pa0, pa1;

  always #(CLK_NS/2) clk = ~clk;

  lookahead_btb #(.PC_W(32), .IDX_W(4), .LOOK(KA)) u0 (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pc(br_pc),
    .br_taken(br_taken), .br_target(br_target), .pred_valid(pv0), .pred_addr(pa0));
  lookahead_btb #(.PC_W(32), .IDX_W(4), .LOOK(0)) u1 (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pc(br_pc),
    .br_taken(br_taken), .br_target(br_target), .pred_valid(pv1), .pred_addr(pa1));

  int checks = 0, errors = 0;
  string tag_now = "R1";

  int          m_vld  [2][16];
  logic [27:0] m_tag  [2][16];
  logic [31:0] m_addr [2][16][4];
  int          m_cnt  [2][16][4];
  logic [31:0] hq0[$];
  logic [31:0] hq1[$];
  bit          ev [2];
  logic [31:0] ea [2];

  task automatic model_step(int n, int kk, bit v, logic [31:0] pc, bit tk, logic [31:0] tg);
    int nc, li, b, ui, mj, vj;
    logic [31:0] src;
    bit full;
    nc = 1 << kk;
    ev[n] = 0;
    ea[n] = '0;
    if (!v) return;
    li = int'(pc[3:0]);
    if (m_vld[n][li] != 0 && m_tag[n][li] == pc[31:4]) begin
      b = 0;
      for (int j = 1; j < nc; j++) if (m_cnt[n][li][j] > m_cnt[n][li][b]) b = j;
      if (m_cnt[n][li][b] > 0) begin ev[n] = 1; ea[n] = m_addr[n][li][b]; end
    end
    if (kk == 0) begin full = 1; src = pc; end
    else if (n == 0) begin full = (hq0.size() == kk); src = full ? hq0[0] : '0; end
    else begin full = (hq1.size() == kk); src = full ? hq1[0] : '0; end
    if (tk && full) begin
      ui = int'(src[3:0]);
      if (!(m_vld[n][ui] != 0 && m_tag[n][ui] == src[31:4])) begin
        m_vld[n][ui] = 1;
        m_tag[n][ui] = src[31:4];
        for (int j = 0; j < nc; j++) begin m_addr[n][ui][j] = '0; m_cnt[n][ui][j] = 0; end
        m_addr[n][ui][0] = tg;
        m_cnt[n][ui][0] = 1;
      end else begin
        mj = -1;
        for (int j = 0; j < nc; j++)
          if (mj < 0 && m_cnt[n][ui][j] > 0 && m_addr[n][ui][j] == tg) mj = j;
        vj = 0;
        for (int j = 0; j < nc; j++) if (m_cnt[n][ui][j] < m_cnt[n][ui][vj]) vj = j;
        for (int j = 0; j < nc; j++) begin
          if (mj >= 0 && j == mj) m_cnt[n][ui][j] = (m_cnt[n][ui][j] < 3) ? m_cnt[n][ui][j] + 1 : 3;
          else if (mj < 0 && j == vj) begin m_addr[n][ui][j] = tg; m_cnt[n][ui][j] = 1; end
          else m_cnt[n][ui][j] = (m_cnt[n][ui][j] > 0) ? m_cnt[n][ui][j] - 1 : 0;
        end
      end
    end
    if (kk > 0) begin
      if (n == 0) begin hq0.push_back(pc); if (hq0.size() > kk) void'(hq0.pop_front()); end
      else begin hq1.push_back(pc); if (hq1.size() > kk) void'(hq1.pop_front()); end
    end
  endtask

  task automatic compare();
    checks++;
    if (pv0 !== ev[0] || (ev[0] && pa0 !== ea[0])) begin
      errors++;
      $display("FAIL %s u0 valid=%0b addr=%h expected valid=%0b addr=%h", tag_now, pv0, pa0, ev[0], ea[0]);
    end
    checks++;
    if (pv1 !== ev[1] || (ev[1] && pa1 !== ea[1])) begin
      errors++;
      $display("FAIL %s u1 valid=%0b addr=%h expected valid=%0b addr=%h", tag_now, pv1, pa1, ev[1], ea[1]);
    end
  endtask

  task automatic drive(bit v, logic [31:0] pc, bit tk, logic [31:0] tg);
    @(negedge clk);
    compare();
    br_valid = v; br_pc = pc; br_taken = tk; br_target = tg;
    model_step(0, KA, v, pc, tk, tg);
    model_step(1, 0, v, pc, tk, tg);
  endtask

  function automatic logic [31:0] mkpc(int t, int i);
    return (32'(t) << 4) | 32'(i);
  endfunction

  task automatic hand_check(string r, bit got_v, logic [31:0] got_a, bit exp_v, logic [31:0] exp_a);
    checks++;
    if (got_v !== exp_v || (exp_v && got_a !== exp_a)) begin
      errors++;
      $display("FAIL %s valid=%0b addr=%h expected valid=%0b addr=%h", r, got_v, got_a, exp_v, exp_a);
    end
  endtask

  initial begin
    for (int n = 0; n < 2; n++)
      for (int e = 0; e < 16; e++) begin
        m_vld[n][e] = 0;
        m_tag[n][e] = '0;
        for (int j = 0; j < 4; j++) begin m_cnt[n][e][j] = 0; m_addr[n][e][j] = '0; end
      end
    ev[0] = 0; ev[1] = 0; ea[0] = '0; ea[1] = '0;
    repeat (3) @(negedge clk);
    tag_now = "R1";
    hand_check("R1", pv0, pa0, 1'b0, '0);
    hand_check("R1", pv1, pa1, 1'b0, '0);
    rst_n = 1'b1;

    // R4: first KA taken branches leave u0's table empty
    tag_now = "R4";
    drive(1, mkpc(1, 0), 1, 32'h100);
    drive(1, mkpc(1, 0), 1, 32'h100);
    drive(1, mkpc(1, 0), 0, 32'h0);
    drive(0, 0, 0, 0);
    hand_check("R4", pv0, pa0, 1'b0, '0);
    hand_check("R9", pv1, pa1, 1'b1, 32'h100);

    // R5: A, B, C(taken to T) trains A's entry; then A predicts T on u0
    tag_now = "R5";
    drive(1, mkpc(2, 5), 1, 32'h200);
    drive(1, mkpc(2, 6), 0, 32'h0);
    drive(1, mkpc(2, 7), 1, 32'h500);
    drive(1, mkpc(2, 5), 0, 32'h0);
    drive(0, 0, 0, 0);
    hand_check("R5", pv0, pa0, 1'b1, 32'h500);

    // R2: alias with a different tag gives no prediction
    tag_now = "R2";
    drive(1, mkpc(9, 5), 0, 32'h0);
    drive(0, 0, 0, 0);
    hand_check("R2", pv0, pa0, 1'b0, '0);

    // R10: lookup and update of the same entry in one cycle
    tag_now = "R10";
    for (int r = 0; r < 6; r++) drive(1, mkpc(3, 2), 1, 32'h1000 + 32'(r));

    // R7/R3: repeating loop strengthens counters
    tag_now = "R7";
    for (int r = 0; r < 12; r++)
      for (int i = 0; i < 4; i++) drive(1, mkpc(4, 8 + i), 1, 32'h4000 + 32'(i));

    // R8/R3: varying targets force replacement and ties
    tag_now = "R8";
    for (int r = 0; r < 300; r++)
      drive(1, mkpc(5, r % 3), ($urandom % 4) != 0, 32'h8000 + 32'($urandom % 6));

    // R6/R9: mixed random with aliasing tags and idle cycles
    tag_now = "R6";
    for (int r = 0; r < 3000; r++) begin
      if (($urandom % 5) == 0) drive(0, 0, 0, 0);
      else drive(1, mkpc(int'($urandom % 3), int'($urandom % 16)), ($urandom % 3) != 0,
                 32'hC000 + 32'($urandom % 5));
    end
    tag_now = "R3";
    drive(0, 0, 0, 0);
    drive(0, 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule